// File: doc/BRIEF.md
# Split Serial Data Register for a Dual-Port Video Memory

This block is the serial side of a dual-port video memory. It holds a 512-word by 4-bit register that exchanges a whole row with the main array in one clock. A pointer walks the register one word per serial clock, and the word under the pointer is presented at the serial data port. The register is loaded from the array by a read transfer. After a write transfer it captures serial input words, which a later write transfer hands back to the array.

The register can also run as two 256-word halves. A split transfer moves data between the array and the half that the pointer is not in. When the pointer reaches the end of its half, it jumps into the other half at the start offset of the last split transfer. This lets a display stream read pixels without a gap while the next line is fetched. A flag shows which half the pointer is in. A split transfer aimed at the half in use is refused and sets a sticky error bit. The whole block runs on the serial clock. The array, refresh and analog timing are outside it.

Top module: `split_serial_buffer`

## Requirements
- R1: A synchronous active-low reset puts the pointer at word 0, clears split mode, the error bit and the half flag, and selects output mode.
- R2: A full read transfer (request high, split low, direction low) loads all 512 words from `row_in` (word i in bits 4i+3..4i) in one clock and sets the pointer to `xfer_start`. After it the register is in output mode.
- R3: A full write transfer (direction high) drives `row_wr` to 2'b11 in the request cycle, with `row_out` carrying the register contents in the same word order. It then sets the pointer to `xfer_start` and selects input mode.
- R4: Every clock without a full transfer advances the pointer by one, whether or not `ser_en` is high. Outside split mode, word 511 is followed by word 0.
- R5: `ser_oe` is high only while `ser_en` is high and the register is in output mode. `ser_dout` always shows the word under the pointer.
- R6: In input mode with `ser_en` high, each clock stores `ser_din` into the word under the pointer. With `ser_en` low, nothing is stored.
- R7: A split transfer addresses the half named by `xfer_start[8]` (0 lower, 1 upper). A split read loads only that half from `row_in` and leaves the other half and the pointer's stepping untouched.
- R8: In split mode, the step after the last word of a half (offset 255) lands in the other half at offset `xfer_start[7:0]` of the last accepted split transfer.
- R9: A split transfer whose target half equals the pointer's current half changes no data, keeps `row_wr` at 0, and sets `split_err`. `split_err` stays set until reset.
- R10: `half_flag` is 0 while the pointer is in words 0..255 and 1 while it is in words 256..511.
- R11: A split write transfer drives only the target half's bit of `row_wr` (bit 0 lower, bit 1 upper) in the request cycle, with `row_out` carrying the register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_en | input | 1 | Serial port enable |
| ser_din | input | 4 | Serial write data |
| ser_dout | output | 4 | Word under the pointer |
| ser_oe | output | 1 | Serial output drive enable (low models high impedance) |
| xfer_req | input | 1 | Transfer request for this clock |
| xfer_split | input | 1 | 1 selects a half transfer, 0 a full-row transfer |
| xfer_to_array | input | 1 | 1 moves register data to the array, 0 loads the register |
| xfer_start | input | 9 | Pointer start (full) or target half and crossing offset (split) |
| row_in | input | 2048 | Row read from the array |
| row_out | output | 2048 | Register contents for the array |
| row_wr | output | 2 | Per-half write strobe to the array |
| half_flag | output | 1 | Half the pointer is in |
| split_err | output | 1 | Sticky refused-split indicator |

## Verification
The bench aims at pointer edges: starts at 255, 510 and 511, the 511-to-0 wrap, and the jump between halves in split mode. A design that stepped through the boundary linearly in split mode would output stale words from the wrong half. A split read followed by a split write of the other half shows whether a load spilled across halves. A refused split is checked both at `row_wr` and through the unchanged stream. Serial writes with the enable low are read back through a write transfer, which exposes a design that stores on every clock.

// File: rtl/ssb_pkg.sv
// Shared types for the split serial data register.
// Assumes: one transfer decision per serial clock.
package ssb_pkg;
    typedef enum logic [1:0] {
        XK_NONE  = 2'd0,   // no transfer this clock
        XK_FULL  = 2'd1,   // whole-row transfer
        XK_SPLIT = 2'd2,   // accepted half transfer
        XK_BAD   = 2'd3    // half transfer aimed at the active half
    } xfer_kind_e;
endpackage

// File: rtl/ssb_pointer.sv
// Serial pointer, split-mode state and sticky error bit.
// Assumes: kind is decoded from the pointer value held before this edge.
module ssb_pointer
    import ssb_pkg::*;
#(
    parameter int DEPTH = 512,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  xfer_kind_e    kind,
    input  logic [AW-1:0] xfer_start,
    output logic [AW-1:0] ptr,
    output logic          err
);
    logic          split_mode;
    logic [AW-2:0] cross_ofs;
    logic          at_half_end;
    logic [AW-1:0] ptr_step;

    // Next pointer value when no full transfer reloads it.
    always_comb begin
        at_half_end = split_mode && (&ptr[AW-2:0]);
        if (at_half_end)
            ptr_step = {~ptr[AW-1], cross_ofs};
        else
            ptr_step = ptr + 1'b1;
    end

    // Pointer, split mode, crossing offset and error state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr        <= '0;
            split_mode <= 1'b0;
            cross_ofs  <= '0;
            err        <= 1'b0;
        end else begin
            case (kind)
                XK_FULL: begin
                    ptr        <= xfer_start;
                    split_mode <= 1'b0;
                end
                XK_SPLIT: begin
                    ptr        <= ptr_step;
                    split_mode <= 1'b1;
                    cross_ofs  <= xfer_start[AW-2:0];
                end
                XK_BAD: begin
                    ptr <= ptr_step;
                    err <= 1'b1;
                end
                default: ptr <= ptr_step;
            endcase
        end
    end

    AST_FULL_SETS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == XK_FULL) |=> (ptr == $past(xfer_start))); // R2
    AST_PTR_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != XK_FULL && !at_half_end) |=> (ptr == $past(ptr) + 1'b1)); // R4
    AST_HALF_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != XK_FULL && at_half_end) |=>
            (ptr[AW-1] != $past(ptr[AW-1]) && ptr[AW-2:0] == $past(cross_ofs))); // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err); // R9
endmodule

// File: rtl/ssb_store.sv
// Word storage of the serial register plus the input/output mode bit.
// Assumes: at most one load source per word per clock; loads win over serial writes.
module ssb_store
    import ssb_pkg::*;
#(
    parameter int W     = 4,
    parameter int DEPTH = 512,
    localparam int AW   = $clog2(DEPTH),
    localparam int HALF = DEPTH / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  xfer_kind_e       kind,
    input  logic             to_array,
    input  logic             tgt_half,
    input  logic             ser_en,
    input  logic [W-1:0]     ser_din,
    input  logic [AW-1:0]    ptr,
    input  logic [DEPTH*W-1:0] row_in,
    output logic [DEPTH*W-1:0] row_out,
    output logic [W-1:0]     dout,
    output logic             in_mode
);
    logic [W-1:0] mem [DEPTH];
    logic         full_load;
    logic         half_load;

    // Load qualifiers for this clock.
    always_comb begin
        full_load = (kind == XK_FULL) && !to_array;
        half_load = (kind == XK_SPLIT) && !to_array;
    end

    // Per-word update: row load, half load or serial write.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (full_load || (half_load && ((i >= HALF) == tgt_half)))
                mem[i] <= row_in[i*W +: W];
            else if (in_mode && ser_en && ptr == AW'(i))
                mem[i] <= ser_din;
        end
    end

    // Serial direction follows the last full transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)
            in_mode <= 1'b0;
        else if (kind == XK_FULL)
            in_mode <= to_array;
    end

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_rowout
            assign row_out[g*W +: W] = mem[g];
        end
    endgenerate

    assign dout = mem[ptr];

    AST_ROW_LOAD_W0: assert property (@(posedge clk) disable iff (!rst_n)
        full_load |=> (row_out[W-1:0] == $past(row_in[W-1:0]))); // R2
    AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == XK_NONE && !ser_en) |=> (row_out == $past(row_out))); // R6
    AST_LOWER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (half_load && tgt_half && !(in_mode && ser_en)) |=>
            (row_out[HALF*W-1:0] == $past(row_out[HALF*W-1:0]))); // R7
endmodule

// File: rtl/split_serial_buffer.sv
// Top of the split serial data register: decodes transfers, drives array strobes.
// Assumes: transfer inputs are synchronous to the serial clock.
module split_serial_buffer
    import ssb_pkg::*;
#(
    parameter int W     = 4,
    parameter int DEPTH = 512,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_en,
    input  logic [W-1:0]       ser_din,
    output logic [W-1:0]       ser_dout,
    output logic               ser_oe,
    input  logic               xfer_req,
    input  logic               xfer_split,
    input  logic               xfer_to_array,
    input  logic [AW-1:0]      xfer_start,
    input  logic [DEPTH*W-1:0] row_in,
    output logic [DEPTH*W-1:0] row_out,
    output logic [1:0]         row_wr,
    output logic               half_flag,
    output logic               split_err
);
    xfer_kind_e    kind;
    logic [AW-1:0] ptr;
    logic          in_mode;
    logic          tgt_half;

    // Classify the request against the half currently in use.
    always_comb begin
        tgt_half = xfer_start[AW-1];
        if (!xfer_req)
            kind = XK_NONE;
        else if (!xfer_split)
            kind = XK_FULL;
        else if (tgt_half == ptr[AW-1])
            kind = XK_BAD;
        else
            kind = XK_SPLIT;
    end

    // Array write strobes per half.
    always_comb begin
        row_wr = 2'b00;
        if (xfer_to_array) begin
            if (kind == XK_FULL)
                row_wr = 2'b11;
            else if (kind == XK_SPLIT)
                row_wr = tgt_half ? 2'b10 : 2'b01;
        end
    end

    ssb_pointer #(.DEPTH(DEPTH)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .kind       (kind),
        .xfer_start (xfer_start),
        .ptr        (ptr),
        .err        (split_err)
    );

    ssb_store #(.W(W), .DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .kind     (kind),
        .to_array (xfer_to_array),
        .tgt_half (tgt_half),
        .ser_en   (ser_en),
        .ser_din  (ser_din),
        .ptr      (ptr),
        .row_in   (row_in),
        .row_out  (row_out),
        .dout     (ser_dout),
        .in_mode  (in_mode)
    );

    assign ser_oe    = ser_en && !in_mode;
    assign half_flag = ptr[AW-1];

    AST_SPLIT_ONE_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && xfer_split) |-> (row_wr != 2'b11)); // R11
    AST_REFUSED_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && xfer_split && xfer_start[AW-1] == half_flag) |-> (row_wr == 2'b00)); // R9
    AST_REFUSED_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && xfer_split && xfer_start[AW-1] == half_flag) |=> split_err); // R9
endmodule

// File: tb/split_serial_buffer_test.sv
module split_serial_buffer_test;
    localparam int W = 4;
    localparam int DEPTH = 512;
    localparam int HALF = DEPTH / 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_en = 1'b0;
    logic [W-1:0] ser_din = '0;
    logic [W-1:0] ser_dout;
    logic ser_oe;
    logic xfer_req = 1'b0, xfer_split = 1'b0, xfer_to_array = 1'b0;
    logic [8:0] xfer_start = '0;
    logic [DEPTH*W-1:0] row_in = '0;
    logic [DEPTH*W-1:0] row_out;
    logic [1:0] row_wr;
    logic half_flag, split_err;

    int checks = 0;
    int fails = 0;

    // Reference model state
    logic [W-1:0] m_mem [DEPTH];
    logic [8:0] m_ptr;
    logic m_split, m_in, m_err;
    logic [7:0] m_ofs;

    always #2 clk = ~clk;

    split_serial_buffer uut (
        .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ser_din(ser_din),
        .ser_dout(ser_dout), .ser_oe(ser_oe), .xfer_req(xfer_req),
        .xfer_split(xfer_split), .xfer_to_array(xfer_to_array),
        .xfer_start(xfer_start), .row_in(row_in), .row_out(row_out),
        .row_wr(row_wr), .half_flag(half_flag), .split_err(split_err)
    );

    // seed 1: {seed, start, extra steps}
    localparam int TBL [6][3] = '{
        '{1, 0, 3}, '{2, 250, 10}, '{3, 510, 4},
        '{4, 255, 0}, '{5, 511, 1}, '{6, 100, 300}
    };

    function automatic logic [W-1:0] wd(int seed, int i);
        return W'(i * 5 + seed * 3 + i / 16);
    endfunction

    function automatic logic [DEPTH*W-1:0] mkrow(int seed);
        logic [DEPTH*W-1:0] r;
        for (int i = 0; i < DEPTH; i++) r[i*W +: W] = wd(seed, i);
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Count words of a row range differing from the model.
    function automatic int row_diff(int lo, int hi);
        int n = 0;
        for (int i = lo; i < hi; i++)
            if (row_out[i*W +: W] !== m_mem[i]) n++;
        return n;
    endfunction

    task automatic model_reset();
        m_ptr = '0; m_split = 1'b0; m_in = 1'b0; m_err = 1'b0; m_ofs = '0;
    endtask

    // One serial clock with the given inputs; the model follows the requirements.
    task automatic step(input bit en, input logic [W-1:0] din, input bit req,
                        input bit spl, input bit toa, input logic [8:0] start,
                        input int seed, input string tag);
        logic [8:0] nxt;
        logic [1:0] exp_wr;
        bit full, sok, bad;
        @(negedge clk);
        ser_en = en; ser_din = din; xfer_req = req; xfer_split = spl;
        xfer_to_array = toa; xfer_start = start; row_in = mkrow(seed);
        #1;
        full = req && !spl;
        sok  = req && spl && (start[8] != m_ptr[8]);
        bad  = req && spl && (start[8] == m_ptr[8]);
        exp_wr = 2'b00;
        if (toa && full) exp_wr = 2'b11;
        else if (toa && sok) exp_wr = start[8] ? 2'b10 : 2'b01;
        if (req) begin
            chk(row_wr === exp_wr, tag, "row_wr", 32'(row_wr), 32'(exp_wr));
            if (exp_wr[0]) chk(row_diff(0, HALF) == 0, tag, "row_out lower", 32'(row_diff(0, HALF)), 0);
            if (exp_wr[1]) chk(row_diff(HALF, DEPTH) == 0, tag, "row_out upper", 32'(row_diff(HALF, DEPTH)), 0);
        end
        nxt = (m_split && m_ptr[7:0] == 8'hFF) ? {~m_ptr[8], m_ofs} : m_ptr + 9'd1;
        if (m_in && en) m_mem[m_ptr] = din;
        if (full && !toa)
            for (int i = 0; i < DEPTH; i++) m_mem[i] = wd(seed, i);
        if (sok && !toa)
            for (int i = 0; i < HALF; i++) m_mem[(start[8] ? HALF : 0) + i] = wd(seed, (start[8] ? HALF : 0) + i);
        if (full) begin
            m_ptr = start; m_split = 1'b0; m_in = toa;
        end else begin
            m_ptr = nxt;
            if (sok) begin m_split = 1'b1; m_ofs = start[7:0]; end
            if (bad) m_err = 1'b1;
        end
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input bit en);
        step(en, '0, 1'b0, 1'b0, 1'b0, '0, 0, "");
    endtask

    // Watchdog: a hung run is a failure.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int bad_words;
        for (int i = 0; i < DEPTH; i++) m_mem[i] = 'x;
        model_reset();
        ser_en = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(half_flag === 1'b0, "R1", "half_flag", 32'(half_flag), 0);
        chk(split_err === 1'b0, "R1", "split_err", 32'(split_err), 0);
        chk(ser_oe === 1'b1, "R1", "ser_oe output mode", 32'(ser_oe), 1);

        // Table: full read at a start, then steps; R2 R4 R10
        for (int t = 0; t < 6; t++) begin
            step(1'b1, '0, 1'b1, 1'b0, 1'b0, 9'(TBL[t][1]), TBL[t][0], "R2");
            for (int s = 0; s < TBL[t][2]; s++) idle(1'b1);
            chk(ser_dout === m_mem[m_ptr], "R2", "ser_dout after load", 32'(ser_dout), 32'(m_mem[m_ptr]));
            chk(half_flag === m_ptr[8], "R10", "half_flag", 32'(half_flag), 32'(m_ptr[8]));
            chk(ser_oe === 1'b1, "R5", "ser_oe read mode", 32'(ser_oe), 1);
        end

        // Full walk with wrap; R4
        step(1'b1, '0, 1'b1, 1'b0, 1'b0, 9'd0, 7, "R2");
        bad_words = 0;
        for (int s = 0; s < DEPTH + 2; s++) begin
            if (ser_dout !== wd(7, (s % DEPTH))) bad_words++;
            idle(1'b1);
        end
        chk(bad_words == 0, "R4", "walk with 511->0 wrap mismatches", 32'(bad_words), 0);

        // Enable low: no drive, pointer still advances; R5 R4
        idle(1'b0);
        chk(ser_oe === 1'b0, "R5", "ser_oe with enable low", 32'(ser_oe), 0);
        idle(1'b0);
        idle(1'b1);
        chk(ser_dout === m_mem[m_ptr], "R4", "pointer advanced while disabled", 32'(ser_dout), 32'(m_mem[m_ptr]));

        // Write transfer and serial input; R3 R6
        step(1'b1, '0, 1'b1, 1'b0, 1'b0, 9'd0, 8, "R2");
        step(1'b1, '0, 1'b1, 1'b0, 1'b1, 9'd20, 0, "R3");
        chk(ser_oe === 1'b0, "R5", "ser_oe in input mode", 32'(ser_oe), 0);
        step(1'b1, 4'hA, 1'b0, 1'b0, 1'b0, '0, 0, "");
        step(1'b1, 4'hB, 1'b0, 1'b0, 1'b0, '0, 0, "");
        step(1'b0, 4'hF, 1'b0, 1'b0, 1'b0, '0, 0, "");
        step(1'b1, 4'hC, 1'b0, 1'b0, 1'b0, '0, 0, "");
        step(1'b1, '0, 1'b1, 1'b0, 1'b1, 9'd0, 0, "R6");
        chk(row_out[20*W +: W] === 4'hA, "R6", "word 20 written", 32'(row_out[20*W +: W]), 32'hA);
        chk(row_out[22*W +: W] === wd(8, 22), "R6", "word 22 kept with enable low", 32'(row_out[22*W +: W]), 32'(wd(8, 22)));
        chk(row_out[23*W +: W] === 4'hC, "R6", "word 23 written", 32'(row_out[23*W +: W]), 32'hC);

        // Split read of upper while in lower; R7 R8 R10
        step(1'b1, '0, 1'b1, 1'b0, 1'b0, 9'd0, 9, "R2");
        step(1'b1, '0, 1'b1, 1'b1, 1'b0, 9'h110, 10, "R7");
        chk(split_err === 1'b0, "R7", "split accepted", 32'(split_err), 0);
        chk(ser_dout === wd(9, 1), "R7", "lower stream continues", 32'(ser_dout), 32'(wd(9, 1)));
        for (int s = 0; s < 300 && m_ptr[8] == 1'b0; s++) idle(1'b1);
        chk(ser_dout === wd(10, 9'h110), "R8", "crossing lands at split offset", 32'(ser_dout), 32'(wd(10, 9'h110)));
        chk(half_flag === 1'b1, "R10", "half_flag upper", 32'(half_flag), 1);

        // Refused split to the active half; R9
        step(1'b1, '0, 1'b1, 1'b1, 1'b0, 9'h100, 11, "R9");
        chk(split_err === 1'b1, "R9", "split_err set", 32'(split_err), 1);
        chk(ser_dout === m_mem[m_ptr], "R9", "data unchanged", 32'(ser_dout), 32'(m_mem[m_ptr]));

        // Split write of lower half; lower untouched by earlier split read; R11 R7
        step(1'b1, '0, 1'b1, 1'b1, 1'b1, 9'h005, 0, "R11");
        chk(m_mem[3] === wd(9, 3), "R7", "model lower half from full load", 32'(m_mem[3]), 32'(wd(9, 3)));

        // Split read of lower, cross back; R8 R9
        step(1'b1, '0, 1'b1, 1'b1, 1'b0, 9'h020, 12, "R7");
        for (int s = 0; s < 300 && m_ptr[8] == 1'b1; s++) idle(1'b1);
        chk(ser_dout === wd(12, 9'h020), "R8", "crossing back to lower", 32'(ser_dout), 32'(wd(12, 9'h020)));
        chk(half_flag === 1'b0, "R10", "half_flag lower", 32'(half_flag), 0);
        chk(split_err === 1'b1, "R9", "split_err sticky", 32'(split_err), 1);

        // Reset clears error and pointer; R1
        @(negedge clk);
        rst_n = 1'b0;
        xfer_req = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        #1;
        chk(split_err === 1'b0, "R1", "split_err after reset", 32'(split_err), 0);
        chk(half_flag === 1'b0, "R1", "half_flag after reset", 32'(half_flag), 0);
        chk(ser_oe === 1'b1, "R1", "output mode after reset", 32'(ser_oe), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule